// File: doc/BRIEF.md
# Saturating-Counter Branch Prediction Table

This block is a direct-mapped table of small saturating counters used to guess whether a conditional branch will be taken. The fetch stage presents an instruction address on the lookup port and receives a taken or not-taken guess in the same cycle, with no register in the path. Later, when the branch resolves, the execute stage presents the branch's address and its real direction on the update port. The selected counter then moves one step toward that direction at the next clock edge.

Each counter is `CNT_W` bits wide, 2 by default. It saturates at zero and at its all-ones value. The guess is "taken" when the counter sits in the upper half of its range. With two bits, the values 0 to 3 stand for strongly not-taken, weakly not-taken, weakly taken and strongly taken. The table is indexed only by address bits above the two byte-offset bits, since instructions are four bytes long. It has no tags, so branches whose addresses share those bits share one counter.

Top module: `bpred_table`

## Requirements
- R1: The entry is selected by PC bits [IDX_W+1:2]. All other PC bits are ignored, so two addresses that agree in those bits share one counter.
- R2: While reset is low, and after it is released, every counter holds 2^(CNT_W-1)-1, which is the weakly not-taken value (1 for CNT_W=2). Every lookup therefore predicts not-taken, and a single taken update to an entry makes that entry predict taken.
- R3: `lk_taken` is 1 exactly when the selected counter is at least 2^(CNT_W-1), which is half of its maximum value rounded up. For CNT_W=2 this means values 2 and 3.
- R4: A taken update on a counter already at 2^CNT_W-1 leaves it at 2^CNT_W-1.
- R5: A not-taken update on a counter already at 0 leaves it at 0.
- R6: A valid update with `up_taken`=1 adds one to the selected counter, and one with `up_taken`=0 subtracts one. The new value is seen by lookups from the clock edge that captures the update onward.
- R7: When `up_valid` is 0, no counter changes, whatever `up_pc` and `up_taken` hold.
- R8: When a lookup and an update select the same entry in the same cycle, the lookup returns the prediction from the value held before that update.
- R9: An update changes only the entry it selects. All other entries keep their values.
- R10: With CNT_W=2, a counter saturated at strongly taken needs two consecutive not-taken updates before it predicts not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch address to predict for |
| lk_taken | output | 1 | Combinational prediction, 1 means taken |
| up_valid | input | 1 | Update strobe for the resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 means taken |

## Verification
A corrupted counter shows at the port only when it crosses the threshold, so a wrong value can stay hidden until the next lookup of that entry after enough updates. For that reason the bench walks single entries through every value and both saturation ends, and it looks up each entry in the cycle after each step. A wrong index, threshold, step direction or reset value shows on `lk_taken` within one or two cycles of the update that exposes it. Long random runs over a small set of hot entries keep a model of every counter and compare each prediction, so drift in any one entry is caught at its next use.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

   // Largest value an n-bit counter may hold.
   function automatic int unsigned cnt_top(input int unsigned w);
      return (32'd1 << w) - 32'd1;
   endfunction

   // Reset value: one step below the taken threshold.
   function automatic int unsigned cnt_start(input int unsigned w);
      return (32'd1 << (w - 1)) - 32'd1;
   endfunction

   // Smallest value that yields a taken guess.
   function automatic int unsigned cnt_threshold(input int unsigned w);
      return 32'd1 << (w - 1);
   endfunction

endpackage

// File: rtl/bpred_index.sv
module bpred_index #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 6
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   localparam int unsigned LO = 2;
   localparam int unsigned HI = IDX_W + LO - 1;

   if (PC_W <= HI + 1) begin : g_bad_width
      $error("bpred_index: PC_W must exceed IDX_W+2");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("bpred_index: IDX_W must be at least 1");
   end

   // Byte-offset bits and bits above the index take no part (R1).
   assign idx = pc[HI:LO];

   logic unused_bits;
   assign unused_bits = ^{pc[PC_W-1:HI+1], pc[LO-1:0]};

endmodule

// File: rtl/bpred_counter.sv
module bpred_counter #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             taken,
   output logic [CNT_W-1:0] cnt
);
   import bpred_pkg::*;

   localparam logic [CNT_W-1:0] TOP   = CNT_W'(cnt_top(CNT_W));
   localparam logic [CNT_W-1:0] START = CNT_W'(cnt_start(CNT_W));
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO  = '0;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("bpred_counter: CNT_W must lie in 1..16");
   end

   if (CNT_W == 1) begin : g_last_outcome
      // A one-bit counter simply remembers the last outcome.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  cnt <= START;
         else if (en) cnt <= taken;
      end
   end else begin : g_saturating
      logic at_top, at_bottom;
      logic [CNT_W-1:0] cnt_nx;

      assign at_top    = (cnt == TOP);
      assign at_bottom = (cnt == ZERO);

      always_comb begin
         cnt_nx = cnt;
         if (taken && !at_top)        cnt_nx = cnt + ONE;
         else if (!taken && !at_bottom) cnt_nx = cnt - ONE;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  cnt <= START;
         else if (en) cnt <= cnt_nx;
      end
   end

   a_r2_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> cnt == START);
   a_r6_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (en && taken && cnt != TOP) |=> cnt == $past(cnt) + ONE);
   a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !taken && cnt != ZERO) |=> cnt == $past(cnt) - ONE);
   a_r4_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
      (en && taken && cnt == TOP) |=> cnt == TOP);
   a_r5_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !taken && cnt == ZERO) |=> cnt == ZERO);
   a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt));

endmodule

// File: rtl/bpred_table.sv
module bpred_table #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned CNT_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken
);
   import bpred_pkg::*;

   localparam int unsigned ENTRIES = 1 << IDX_W;
   localparam logic [CNT_W-1:0] HALF = CNT_W'(cnt_threshold(CNT_W));

   if (IDX_W > 10) begin : g_too_deep
      $error("bpred_table: IDX_W above 10 makes an oversized table");
   end

   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [CNT_W-1:0] cnt_all [ENTRIES];
   logic [ENTRIES-1:0] wr_sel;
   logic [CNT_W-1:0] lk_cnt;

   bpred_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_index (
      .pc (lk_pc),
      .idx(lk_idx)
   );

   bpred_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_index (
      .pc (up_pc),
      .idx(up_idx)
   );

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      assign wr_sel[e] = up_valid && (up_idx == IDX_W'(e));
      bpred_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (wr_sel[e]),
         .taken(up_taken),
         .cnt  (cnt_all[e])
      );
   end

   // The read uses the stored value, so a same-cycle update is not seen (R8).
   assign lk_cnt   = cnt_all[lk_idx];
   // The top bit of the counter is set exactly when the value is at least HALF (R3).
   assign lk_taken = lk_cnt[CNT_W-1];

   a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));
   a_r3_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      lk_taken == (lk_cnt >= HALF));

endmodule

// File: tb/bpred_table_bench.sv
`timescale 1ns/1ps
module bpred_table_bench;
   localparam int PC_W = 32;
   localparam int IDX_W = 6;
   localparam int CNT_W = 2;
   localparam int ENTRIES = 1 << IDX_W;
   localparam int TOPV = (1 << CNT_W) - 1;
   localparam int HALFV = 1 << (CNT_W - 1);
   localparam int STARTV = HALFV - 1;

   logic clk = 0;
   logic rst_n = 0;
   logic [PC_W-1:0] lk_pc = '0;
   logic lk_taken;
   logic up_valid = 0;
   logic [PC_W-1:0] up_pc = '0;
   logic up_taken = 0;

   int model [ENTRIES];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bpred_table #(.PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_bpred_table (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
   );

   function automatic int idx_of(input logic [PC_W-1:0] pc);
      return int'(pc[IDX_W+1:2]);
   endfunction

   function automatic int step_model(input int v, input bit t);
      if (t) return (v == TOPV) ? v : v + 1;
      return (v == 0) ? v : v - 1;
   endfunction

   function automatic bit guess(input int v);
      return v >= HALFV;
   endfunction

   function automatic logic [PC_W-1:0] pc_for(input int idx, input logic [PC_W-1:0] noise);
      logic [PC_W-1:0] p;
      p = noise;
      p[IDX_W+1:2] = idx[IDX_W-1:0];
      return p;
   endfunction

   task automatic check(input bit act, input bit exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: lk_taken=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: drive at the falling edge, compare before the rising edge, update the model at it.
   task automatic cycle(input logic [PC_W-1:0] lpc, input bit uv,
                        input logic [PC_W-1:0] upc, input bit ut, input string tag);
      @(negedge clk);
      lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
      #1;
      check(lk_taken, guess(model[idx_of(lpc)]), tag);
      @(posedge clk);
      if (uv) model[idx_of(upc)] = step_model(model[idx_of(upc)], ut);
   endtask

   task automatic upd(input int idx, input bit t, input string tag);
      cycle(pc_for(idx, 32'hA5A5_0000), 1'b1, pc_for(idx, 32'h1234_0001), t, tag);
   endtask

   task automatic look(input int idx, input string tag);
      cycle(pc_for(idx, 32'h0F0F_0003), 1'b0, 32'h0, 1'b0, tag);
   endtask

   initial begin
      void'($urandom(32'd1977));
      for (int e = 0; e < ENTRIES; e++) model[e] = STARTV;

      // R2: the prediction is not-taken while reset is held
      #3;
      check(lk_taken, 1'b0, "R2 during reset");
      @(negedge clk); @(negedge clk);
      rst_n = 1;

      // R2: every entry predicts not-taken after reset
      for (int e = 0; e < ENTRIES; e++) look(e, "R2 reset sweep");

      // R2/R6: a single taken update flips the entry (1 -> 2)
      upd(5, 1'b1, "R6 before up");
      look(5, "R2 one taken flips");
      // R4: saturate at the top (2 -> 3 -> 3)
      upd(5, 1'b1, "R4 climb");
      upd(5, 1'b1, "R4 at top");
      look(5, "R4 held top");
      // R10: the first not-taken keeps the taken guess, the second flips it
      upd(5, 1'b0, "R10 first miss");
      look(5, "R10 still taken");
      upd(5, 1'b0, "R10 second miss");
      look(5, "R10 flipped");
      // R5: saturate at zero, then two taken updates are needed (0 -> 1 -> 2)
      upd(5, 1'b0, "R5 down");
      upd(5, 1'b0, "R5 at zero");
      upd(5, 1'b1, "R5 up from zero");
      look(5, "R5 one step not enough");
      upd(5, 1'b1, "R5 second step");
      look(5, "R5 taken again");

      // R7: an invalid taken update does not move entry 9 (value 1)
      cycle(pc_for(9, 32'h0), 1'b0, pc_for(9, 32'h0), 1'b1, "R7 strobe low");
      cycle(pc_for(9, 32'h0), 1'b0, pc_for(9, 32'h0), 1'b1, "R7 strobe low again");
      upd(9, 1'b1, "R7 one valid step");
      look(9, "R7 value stayed at start");

      // R8: lookup and update on one entry in one cycle return the old guess
      cycle(pc_for(12, 32'h0), 1'b1, pc_for(12, 32'hFFFF_0000), 1'b1, "R8 same cycle old value");
      look(12, "R8 new value next cycle");

      // R1: addresses differing outside the index bits share one counter
      cycle(32'h0, 1'b1, pc_for(20, 32'hDEAD_0003), 1'b1, "R1 alias write");
      cycle(pc_for(20, 32'h7777_0002), 1'b0, 32'h0, 1'b0, "R1 alias read");
      // R9: neighbours of entry 20 are untouched
      look(19, "R9 neighbour below");
      look(21, "R9 neighbour above");

      // Random traffic over a few hot entries plus the whole table
      for (int i = 0; i < 4000; i++) begin
         int li, ui;
         logic [PC_W-1:0] nz;
         nz = $urandom;
         li = ($urandom % 4 == 0) ? int'($urandom % ENTRIES) : int'($urandom % 8);
         ui = ($urandom % 4 == 0) ? int'($urandom % ENTRIES) : int'($urandom % 8);
         cycle(pc_for(li, nz), bit'($urandom % 3 != 0), pc_for(ui, $urandom),
               bit'($urandom % 2), "R6 R9 random");
      end

      // Final sweep compares every entry against the model
      for (int e = 0; e < ENTRIES; e++) look(e, "R9 final sweep");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule